// File: doc/BRIEF.md
# Saturating Parallel-Prefix Adder with Dual-Rail Sum

This combinational block adds two unsigned numbers: a wide operand of `WIDE_W` bits and a narrow operand of `NARROW_W` bits. The narrow operand is zero-extended to the full width. The carry network is a Kogge-Stone parallel-prefix tree. The first level forms per-bit generate (`a AND b`) and propagate (`a XOR b`). The tree then has `clog2(WIDE_W)` merge levels, with spans of 1, 2, 4 and so on. Each bit's carry-in is read directly from the last level of the tree.

An overflow is a carry out of the top bit. On overflow an active-low saturation flag goes low, every true sum bit is forced to 1 and every complement sum bit is forced to 0. The result is therefore clamped to the largest representable value. Both the true sum and the complement sum are presented, because the stages that consume them use dual-rail logic. A typical use is the metric-update adder of a trellis decoder, where a metric must never wrap back to a small value.

Top module: `sat_ks_adder`

## Requirements
- R1: When `wide_op + narrow_op` is at most 2^WIDE_W - 1 (255 by default), `sum_true` equals the exact unsigned sum.
- R2: When there is no overflow, `sum_comp` is the bitwise inverse of `sum_true`.
- R3: When `wide_op + narrow_op` exceeds 255, `sat_n` is 0 (active low).
- R4: When there is no overflow, `sat_n` is 1.
- R5: On overflow, every bit of `sum_true` is 1 (value 255).
- R6: On overflow, every bit of `sum_comp` is 0.
- R7: At the boundary, 255+0 and 224+31 give 255 with `sat_n`=1, while 255+1 and 225+31 give 255 with `sat_n`=0.
- R8: The outputs are a purely combinational function of the inputs. A new operand pair is reflected in the same cycle, with no clock and no held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wide_op | input | WIDE_W (8) | Full-width unsigned operand |
| narrow_op | input | NARROW_W (5) | Narrow unsigned operand, zero-extended internally |
| sum_true | output | WIDE_W (8) | Saturated sum, true rail |
| sum_comp | output | WIDE_W (8) | Saturated sum, complement rail |
| sat_n | output | 1 | Active-low saturation flag (0 = clamped) |

## Verification
The hardest case to reach from the ports is a carry that starts at bit 0 and crosses every propagate position, so that it passes through all prefix levels before it reaches the carry-out. The operand pairs that do this are the ones that just reach or just exceed 255, such as 225+31 and 255+1. An exhaustive sweep of all 256×32 operand pairs covers every such ripple length. Directed vectors pin down the exact boundary pairs where the saturation flag changes.

// File: rtl/sat_ks_pkg.sv
package sat_ks_pkg;

    localparam int WIDE_W   = 8;
    localparam int NARROW_W = 5;

    // Active-low saturation level
    typedef enum logic {
        SAT_ON  = 1'b0,
        SAT_OFF = 1'b1
    } sat_lvl_e;

    // Number of prefix merge levels for a given width
    function automatic int prefix_depth(input int w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/ks_gp_form.sv
module ks_gp_form #(
    parameter int W = sat_ks_pkg::WIDE_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] gen0,
    output logic [W-1:0] prop0
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen0[i]  = op_a[i] & op_b[i];
        assign prop0[i] = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/ks_prefix_tree.sv
module ks_prefix_tree #(
    parameter int W = sat_ks_pkg::WIDE_W
) (
    input  logic [W-1:0] gen0,
    input  logic [W-1:0] prop0,
    output logic [W-1:0] grp_gen
);
    localparam int LEVELS = sat_ks_pkg::prefix_depth(W);

    logic [W-1:0] g_lvl [LEVELS+1];
    logic [W-1:0] p_lvl [LEVELS];

    assign g_lvl[0] = gen0;
    assign p_lvl[0] = prop0;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_node
            if (i >= SPAN) begin : g_merge
                assign g_lvl[l+1][i] = g_lvl[l][i] | (p_lvl[l][i] & g_lvl[l][i-SPAN]);
                if (l < LEVELS - 1) begin : g_pm
                    assign p_lvl[l+1][i] = p_lvl[l][i] & p_lvl[l][i-SPAN];
                end
            end else begin : g_pass
                assign g_lvl[l+1][i] = g_lvl[l][i];
                if (l < LEVELS - 1) begin : g_pp
                    assign p_lvl[l+1][i] = p_lvl[l][i];
                end
            end
        end
    end

    assign grp_gen = g_lvl[LEVELS];
endmodule

// File: rtl/ks_sum_clamp.sv
module ks_sum_clamp #(
    parameter int W = sat_ks_pkg::WIDE_W
) (
    input  logic [W-1:0] prop0,
    input  logic [W-1:0] carry_in,
    input  logic         carry_out,
    output logic [W-1:0] rail_t,
    output logic [W-1:0] rail_f,
    output logic         sat_lvl
);
    import sat_ks_pkg::*;

    sat_lvl_e lvl;
    logic [W-1:0] raw;

    assign lvl = carry_out ? SAT_ON : SAT_OFF;
    assign raw = prop0 ^ carry_in;

    for (genvar i = 0; i < W; i++) begin : g_rail
        always_comb begin
            if (lvl == SAT_ON) begin
                rail_t[i] = 1'b1;
                rail_f[i] = 1'b0;
            end else begin
                rail_t[i] = raw[i];
                rail_f[i] = ~raw[i];
            end
        end
    end

    assign sat_lvl = lvl;
endmodule

// File: rtl/sat_ks_adder.sv
module sat_ks_adder #(
    parameter int WIDE_W   = sat_ks_pkg::WIDE_W,
    parameter int NARROW_W = sat_ks_pkg::NARROW_W
) (
    input  logic [WIDE_W-1:0]   wide_op,
    input  logic [NARROW_W-1:0] narrow_op,
    output logic [WIDE_W-1:0]   sum_true,
    output logic [WIDE_W-1:0]   sum_comp,
    output logic                sat_n
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] narrow_ext;
    logic [WIDE_W-1:0] gen0;
    logic [WIDE_W-1:0] prop0;
    logic [WIDE_W-1:0] grp_gen;
    logic [WIDE_W-1:0] carries;

    assign narrow_ext = {{PAD_W{1'b0}}, narrow_op};

    ks_gp_form #(.W(WIDE_W)) u_gp (
        .op_a  (wide_op),
        .op_b  (narrow_ext),
        .gen0  (gen0),
        .prop0 (prop0)
    );

    ks_prefix_tree #(.W(WIDE_W)) u_tree (
        .gen0    (gen0),
        .prop0   (prop0),
        .grp_gen (grp_gen)
    );

    assign carries = {grp_gen[WIDE_W-2:0], 1'b0};

    ks_sum_clamp #(.W(WIDE_W)) u_clamp (
        .prop0     (prop0),
        .carry_in  (carries),
        .carry_out (grp_gen[WIDE_W-1]),
        .rail_t    (sum_true),
        .rail_f    (sum_comp),
        .sat_lvl   (sat_n)
    );
endmodule

// File: rtl/sat_ks_adder_chk.sv
module sat_ks_adder_chk #(
    parameter int WIDE_W   = sat_ks_pkg::WIDE_W,
    parameter int NARROW_W = sat_ks_pkg::NARROW_W
) (
    input logic [WIDE_W-1:0]   wide_op,
    input logic [NARROW_W-1:0] narrow_op,
    input logic [WIDE_W-1:0]   sum_true,
    input logic [WIDE_W-1:0]   sum_comp,
    input logic                sat_n
);
    logic [WIDE_W:0] ref_sum;
    logic            ovf;

    assign ref_sum = {1'b0, wide_op} + {{(WIDE_W+1-NARROW_W){1'b0}}, narrow_op};
    assign ovf     = ref_sum[WIDE_W];

    always_comb begin
        if (!$isunknown({wide_op, narrow_op})) begin
            if (!ovf) begin
                assert_exact_sum_R1: assert (sum_true == ref_sum[WIDE_W-1:0]);
                assert_comp_inverse_R2: assert ((sum_true ^ sum_comp) == {WIDE_W{1'b1}});
                assert_flag_idle_R4: assert (sat_n == 1'b1);
            end else begin
                assert_flag_low_R3: assert (sat_n == 1'b0);
                assert_true_ones_R5: assert (sum_true == {WIDE_W{1'b1}});
                assert_comp_zero_R6: assert (sum_comp == '0);
            end
        end
    end
endmodule

bind sat_ks_adder sat_ks_adder_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .wide_op   (wide_op),
    .narrow_op (narrow_op),
    .sum_true  (sum_true),
    .sum_comp  (sum_comp),
    .sat_n     (sat_n)
);

// File: tb/sat_ks_adder_test.sv
module sat_ks_adder_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [7:0] wide_op;
    logic [4:0] narrow_op;
    logic [7:0] sum_true;
    logic [7:0] sum_comp;
    logic       sat_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    sat_ks_adder uut (
        .wide_op   (wide_op),
        .narrow_op (narrow_op),
        .sum_true  (sum_true),
        .sum_comp  (sum_comp),
        .sat_n     (sat_n)
    );

    // {wide, narrow, expected sum, expected sat_n}
    localparam logic [21:0] VEC [12] = '{
        {8'd0,   5'd0,  8'd0,   1'b1},
        {8'd255, 5'd0,  8'd255, 1'b1},
        {8'd224, 5'd31, 8'd255, 1'b1},
        {8'd255, 5'd1,  8'd255, 1'b0},
        {8'd225, 5'd31, 8'd255, 1'b0},
        {8'd128, 5'd16, 8'd144, 1'b1},
        {8'd15,  5'd17, 8'd32,  1'b1},
        {8'd127, 5'd1,  8'd128, 1'b1},
        {8'd250, 5'd10, 8'd255, 1'b0},
        {8'd255, 5'd31, 8'd255, 1'b0},
        {8'd85,  5'd10, 8'd95,  1'b1},
        {8'd240, 5'd15, 8'd255, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d)", req, act, exp, wide_op, narrow_op);
        end
    endtask

    task automatic check_all(input int exp_sum, input bit exp_sat, input string tag);
        check(sum_true == exp_sum[7:0], {tag, " R1/R5 sum_true"}, sum_true, exp_sum);
        check(sum_comp == (exp_sat ? ~exp_sum[7:0] : 8'h00), {tag, " R2/R6 sum_comp"},
              sum_comp, exp_sat ? ~exp_sum[7:0] : 8'h00);
        check(sat_n == exp_sat, {tag, " R3/R4 sat_n"}, sat_n, exp_sat);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wide_op   = '0;
        narrow_op = '0;
        @(negedge clk);
        // R8: combinational, settles without a clock edge
        check(sum_true == 8'd0 && sat_n == 1'b1, "R8 initial zero", sum_true, 0);
        wide_op = 8'd200; narrow_op = 5'd20;
        #1;
        check(sum_true == 8'd220, "R8 same-cycle update", sum_true, 220);

        // Directed table, including R7 boundary pairs
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            wide_op   = VEC[k][21:14];
            narrow_op = VEC[k][13:9];
            @(negedge clk);
            check_all(int'(VEC[k][8:1]), VEC[k][0], "R7 table");
        end

        // Exhaustive sweep: R1..R6
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(posedge clk);
                wide_op   = a[7:0];
                narrow_op = b[4:0];
                @(negedge clk);
                check_all((a + b > 255) ? 255 : a + b, (a + b > 255) ? 1'b0 : 1'b1, "sweep");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule